// File: doc/BRIEF.md
# Sequential Generator-Walk Byte Inverter

This block computes the multiplicative inverse of one byte in the binary field of 256 elements. It uses the polynomial basis with reduction polynomial x^8 + x^4 + x^3 + x + 1 (0x11B). It is built for minimum area, and a result takes many cycles. The block never searches a table. It walks through the successive powers of the generator 03, one power per clock, for a fixed 256 steps. An accumulator starts at 01 and is multiplied by 03 on every step. At the first step where the accumulator equals the input, the accumulator drops back to 01. The walk then goes on. When the 256 steps are over, the accumulator holds 03^(255-i) for an input equal to 03^i, which is the inverse. An input of 00 never matches, so it is forced to give 00.

The control is a two-state machine.
- **ST_IDLE** waits for work. The transition *accept* (a `start` seen in ST_IDLE) captures `din`, sets the accumulator to 01, clears the match flag and the step counter, and enters ST_WALK.
- **ST_WALK** performs one step per clock. Its transition *finish* returns to ST_IDLE on the step where the counter reaches 255. That same edge writes the result and raises `done` for one cycle.

While the block is in ST_WALK, `start` has no effect. Latency does not depend on the input value, so the time taken reveals nothing about the operand.

Top module: `gfinv_walk`

## Requirements
- R1: A synchronous reset, `rst` high at a rising edge, makes `done` 0 and `dout` 00, aborts any walk in progress, and leaves the block ready to accept `start` on the next edge.
- R2: For every nonzero input a, the result b written at completion satisfies a·b = 01 in the field defined by 0x11B.
- R3: An input of 00 produces a result of 00.
- R4: `done` is high in the cycle that follows the 256th rising edge after the edge that sampled an accepted `start`. This latency is the same for all 256 input values.
- R5: `done` is high for exactly one cycle per accepted operation.
- R6: A `start` sampled while a walk is in progress is ignored. Neither the operand nor the timing of the running walk changes.
- R7: `dout` keeps its value from one completion to the next, and changes only in the cycle in which `done` is high.
- R8: Only the first match between the accumulator and the operand sends the accumulator back to 01. Later equal values are not treated as matches, so input 01 gives 01 and input 03 gives F6.
- R9: A `start` sampled in the cycle where `done` is high is accepted, so operations can run back to back with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin an inversion; sampled only in ST_IDLE |
| din | input | 8 | Operand, captured in the cycle where `start` is accepted |
| dout | output | 8 | Inverse of the last completed operand, held between completions |
| done | output | 1 | One-cycle pulse marking a new value on `dout` |

## Verification
The assertions take several things for granted. `rst` is synchronous. `din` is meaningful only in the cycle where `start` is accepted. The result is judged against the operand captured at acceptance, not against whatever is on `din` later. The stimulus drives `start` and `din` on the falling edge and holds `start` for a single cycle. It changes `din` freely during walks, and it pulses `start` on purpose during a walk to show that the operand is held. It covers all 256 operands, mixing back-to-back starts with idle gaps, and it includes one reset applied in the middle of a walk.

// File: rtl/gfinv_pkg.sv
package gfinv_pkg;

    // Control states of the generator walk
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } walk_state_t;

endpackage

// File: rtl/gfinv_mul3.sv
// Multiply a field element by the generator 03: xtime(y) ^ y,
// built bit by bit from the reduction constant.
module gfinv_mul3 #(
    parameter int          W   = 8,
    parameter logic [W-1:0] RED = 8'h1B
) (
    input  logic [W-1:0] y,
    output logic [W-1:0] p
);
    logic [W-1:0] shifted;

    assign shifted[0] = y[W-1] & RED[0];

    for (genvar b = 1; b < W; b++) begin : g_bit
        assign shifted[b] = y[b-1] ^ (y[W-1] & RED[b]);
    end

    assign p = shifted ^ y;

endmodule

// File: rtl/gfinv_fsm.sv
// Walk sequencer: idle/walk states and the step counter.
module gfinv_fsm
    import gfinv_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic step,
    output logic last
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    walk_state_t      st_q, st_d;
    logic [CW-1:0]    cnt_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start)           st_d = ST_WALK;   // accept
            ST_WALK: if (cnt_q == CNT_MAX) st_d = ST_IDLE;  // finish
            default:                       st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (load) cnt_q <= '0;
        else if (step) cnt_q <= cnt_q + 1'b1;
    end

    assign load = (st_q == ST_IDLE) && start;
    assign step = (st_q == ST_WALK);
    assign last = step && (cnt_q == CNT_MAX);

    AST_IDLE_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE) |-> (cnt_q == '0));                           // R4
    AST_FINISH_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        last |=> (st_q == ST_IDLE));                                     // R9
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (step && !last && start) |=> (st_q == ST_WALK && cnt_q == $past(cnt_q) + 1'b1)); // R6

endmodule

// File: rtl/gfinv_acc.sv
// Operand register, power accumulator and first-match flag.
module gfinv_acc #(
    parameter int           W   = 8,
    parameter logic [W-1:0] RED = 8'h1B
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] din,
    output logic [W-1:0] x_q,
    output logic [W-1:0] y_next
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] y_q;
    logic [W-1:0] y_mul;
    logic         hit_q;
    logic         match;

    gfinv_mul3 #(.W(W), .RED(RED)) mul3_i (
        .y (y_q),
        .p (y_mul)
    );

    assign match  = !hit_q && (y_q == x_q);
    assign y_next = match ? ONE : y_mul;

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q   <= '0;
            y_q   <= ONE;
            hit_q <= 1'b0;
        end else if (load) begin
            x_q   <= din;
            y_q   <= ONE;
            hit_q <= 1'b0;
        end else if (step) begin
            y_q <= y_next;
            if (match) hit_q <= 1'b1;
        end
    end

    AST_OPERAND_HELD: assert property (@(posedge clk) disable iff (rst)
        step |=> $stable(x_q));                                          // R6
    AST_HIT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (step && hit_q) |=> hit_q);                                      // R8
    AST_ACC_NONZERO: assert property (@(posedge clk) disable iff (rst)
        step |-> (y_q != '0));                                           // R2

endmodule

// File: rtl/gfinv_walk.sv
// Top: byte inverter by generator walk, registered result and done pulse.
module gfinv_walk #(
    parameter int           W   = 8,
    parameter logic [W-1:0] RED = 8'h1B
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         done
);
    localparam int STEPS = 1 << W;

    logic         load, step, last;
    logic [W-1:0] x_q, y_next;
    logic [W-1:0] dout_q;
    logic         done_q;

    gfinv_fsm #(.CW(W)) fsm_i (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .load  (load),
        .step  (step),
        .last  (last)
    );

    gfinv_acc #(.W(W), .RED(RED)) acc_i (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .step   (step),
        .din    (din),
        .x_q    (x_q),
        .y_next (y_next)
    );

    // Output process: result register with zero override, done pulse
    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= last;
            if (last) dout_q <= (x_q == '0) ? '0 : y_next;
        end
    end

    assign dout = dout_q;
    assign done = done_q;

    // Field product used only by the checks below
    function automatic logic [W-1:0] gf_mul(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] acc;
        logic [W-1:0] sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = sh[W-1] ? ((sh << 1) ^ RED) : (sh << 1);
        end
        return acc;
    endfunction

    // Cycles since acceptance, for the latency check
    logic [W:0] lat_q;
    always_ff @(posedge clk) begin
        if (rst)       lat_q <= '0;
        else if (load) lat_q <= '0;
        else if (step) lat_q <= lat_q + 1'b1;
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                 // R5
    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
        done |-> (lat_q == (W+1)'(STEPS)));                              // R4
    AST_ZERO_MAPS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (done && x_q == '0) |-> (dout == '0));                           // R3
    AST_PRODUCT_IS_ONE: assert property (@(posedge clk) disable iff (rst)
        (done && x_q != '0) |-> (gf_mul(x_q, dout) == W'(1)));           // R2
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !last |=> $stable(dout));                                        // R7

endmodule

// File: tb/gfinv_walk_tb_top.sv
`timescale 1ns/1ps
module gfinv_walk_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       done;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    gfinv_walk dut_i (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .din   (din),
        .dout  (dout),
        .done  (done)
    );

    // Behavioural field arithmetic
    function automatic int ref_mul(int a, int b);
        int r = 0;
        for (int i = 0; i < 8; i++) begin
            if (((b >> i) & 1) == 1) r = r ^ a;
            a = a << 1;
            if ((a & 256) != 0) a = a ^ 283;
        end
        return r;
    endfunction

    function automatic int ref_inv(int a);
        if (a == 0) return 0;
        for (int b = 1; b < 256; b++)
            if (ref_mul(a, b) == 1) return b;
        return -1;
    endfunction

    // Cycle reference model
    int m_busy = 0, m_left = 0, m_pend = 0, m_done = 0, m_dout = 0, m_opnd = 0, m_last_opnd = 0;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst) begin
            m_busy <= 0; m_left <= 0; m_done <= 0; m_dout <= 0;
        end else begin
            m_done <= 0;
            if (m_busy == 0) begin
                if (start) begin
                    m_busy <= 1; m_left <= 256;
                    m_pend <= ref_inv(int'(din)); m_opnd <= int'(din);
                end
            end else begin
                m_left <= m_left - 1;
                if (m_left == 1) begin
                    m_busy <= 0; m_done <= 1; m_dout <= m_pend; m_last_opnd <= m_opnd;
                end
            end
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (cycles > 1) begin
            checks++;
            if (int'(done) != m_done) begin
                fails++;
                $display("FAIL R4 done act=%0d exp=%0d at cycle %0d", done, m_done, cycles);
            end
            checks++;
            if (int'(dout) != m_dout) begin
                fails++;
                $display("FAIL R7 dout act=%02h exp=%02h at cycle %0d", dout, m_dout, cycles);
            end
            if (done && m_done == 1) begin
                checks++;
                if (m_last_opnd == 0 && dout != 8'h00) begin
                    fails++;
                    $display("FAIL R3 zero input act=%02h exp=00", dout);
                end else if (m_last_opnd != 0 && ref_mul(m_last_opnd, int'(dout)) != 1) begin
                    fails++;
                    $display("FAIL R2 product for %02h act=%02h exp=01", m_last_opnd,
                             ref_mul(m_last_opnd, int'(dout)));
                end
            end
        end
    end

    task automatic pulse_start(input logic [7:0] v);
        start = 1'b1; din = v;
        @(negedge clk);
        start = 1'b0; din = ~v;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic check_value(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check_value("R1 dout after reset", dout, 8'h00);
        check_value("R1 done after reset", {7'b0, done}, 8'h00);

        // R8: input 01 gives 01
        pulse_start(8'h01);
        wait_done();
        check_value("R8 inverse of 01", dout, 8'h01);

        // R6: start during walk ignored; R8: 03 gives F6
        @(negedge clk);
        pulse_start(8'h03);
        repeat (50) @(negedge clk);
        pulse_start(8'h55);
        wait_done();
        check_value("R6 R8 inverse of 03 after busy start", dout, 8'hF6);

        // R1: reset in the middle of a walk
        @(negedge clk);
        pulse_start(8'h80);
        repeat (20) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_value("R1 dout after mid-walk reset", dout, 8'h00);
        check_value("R1 done after mid-walk reset", {7'b0, done}, 8'h00);

        // R2 R3 R4 R9: all operands, mostly back to back
        for (int v = 0; v < 256; v++) begin
            pulse_start(8'(v));
            wait_done();
            check_value("R2 table result", dout, 8'(ref_inv(v)));
            if (v % 9 == 0) repeat (3) @(negedge clk);
        end

        // R7: result held while idle
        repeat (10) @(negedge clk);
        check_value("R7 held result", dout, 8'(ref_inv(255)));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule